// File: doc/BRIEF.md
# Rotating Column Buffer Pipeline with Screen Merge

This block sits between a waveform renderer and a 2-bit-per-pixel screen memory of 256 columns by 256 rows. It owns three column buffers of 256 entries, 12 bits each. At any time one buffer collects brightness hits for the column being drawn, one collects hits for the column to its right, and the third is drained into the screen memory. When the source moves on by one column, the buffers change roles by advancing a single rotation pointer. No buffer contents are moved.

Draining a buffer is called recombination. For each row it reads the accumulated 12-bit brightness and reduces it to 2 bits with a programmable right shift, clamped to the top code. It then reads the matching screen pixel, writes back the larger of the two values, and clears the buffer entry. Recombination runs while the other two buffers keep taking hits. A new column advance is held off with a busy flag until the drain has finished. The source holds its request until busy drops.

Top module: `colpipe_top`

## Requirements
- R1: After reset, busy_o, scr_re_o and scr_we_o are 0, cur_col_o is 0, and all three buffers hold 0.
- R2: A cycle with hit_valid_i=1 adds hit_wt_i to entry hit_row_i of one buffer, saturating at 4095. hit_next_i=0 selects the current-column buffer and hit_next_i=1 selects the next-column buffer.
- R3: An advance is accepted at a clock edge where adv_req_i=1 and busy_o=0. On acceptance the next buffer becomes current, the drained buffer becomes next, the current buffer goes to recombination, and cur_col_o increments modulo 256.
- R4: In the cycle after acceptance, recombination of the finished column x (the cur_col_o value before the advance) starts. scr_re_o is then high for 256 consecutive cycles, with scr_raddr_o = {x, y} for y = 0, 1, …, 255. Bits [15:8] hold the column and bits [7:0] hold the row.
- R5: The screen memory returns scr_rdata_i one cycle after a read. Each read of {x, y} is followed in the next cycle by scr_we_o=1 at scr_waddr_o={x, y}, with scr_wdata_o = max(scr_rdata_i, q).
- R6: q = min(3, v >> scale_shift_i), where v is the 12-bit buffer value. The shift in effect in the cycle the entry is read is the one used.
- R7: Every entry is cleared after it is read, so a buffer returning as "next" holds 0 everywhere. A column with no hits writes back the unchanged screen pixels.
- R8: busy_o is high for exactly 257 cycles after an accepted advance. adv_req_i asserted while busy_o=1 has no effect: no rotation, no cur_col_o change and no extra screen traffic.
- R9: Hits made during recombination land in the current and next buffers and are reflected when those columns are later drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_valid_i | input | 1 | Brightness hit strobe |
| hit_next_i | input | 1 | 0: current column, 1: next column |
| hit_row_i | input | 8 | Row of the hit |
| hit_wt_i | input | 12 | Brightness added by the hit |
| adv_req_i | input | 1 | Column advance request, held until accepted |
| scale_shift_i | input | 4 | Right shift applied before clamping to 2 bits |
| busy_o | output | 1 | Recombination in progress; advances stalled |
| cur_col_o | output | 8 | Column index of the current buffer |
| scr_re_o | output | 1 | Screen memory read enable |
| scr_raddr_o | output | 16 | Screen read address {column, row} |
| scr_rdata_i | input | 2 | Screen read data, one cycle after scr_re_o |
| scr_we_o | output | 1 | Screen memory write enable |
| scr_waddr_o | output | 16 | Screen write address {column, row} |
| scr_wdata_o | output | 2 | Merged pixel value |

## Verification
An advance is accepted on the edge following the bench's request. The first screen read is due in the very next cycle, and the write for row y follows its read by exactly one cycle, so the last write lands 257 cycles after acceptance. The bench therefore checks scr_re_o and the row-0 address in the first cycle after acceptance. It counts the busy_o cycles against 257, and compares each write against a queue of expected {address, pixel} items in the cycle it appears. Hits take effect at the edge that samples them and are only observed through later drains, which the model tracks by rotating its own copies of the buffers.

// File: rtl/cpipe_pkg.sv
package cpipe_pkg;

    localparam int NBUF = 3;

    typedef logic [1:0] ptr_t;

    // Rotation modulo the number of buffers.
    function automatic ptr_t ptr_add(ptr_t p, ptr_t k);
        logic [2:0] s;
        s = {1'b0, p} + {1'b0, k};
        if (s >= 3'(NBUF)) s = s - 3'(NBUF);
        return s[1:0];
    endfunction

endpackage

// File: rtl/cpipe_roles.sv
module cpipe_roles
    import cpipe_pkg::*;
#(
    parameter int COLS = 256,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_req_i,
    input  logic             busy_i,
    output ptr_t             ptr_o,
    output logic [COL_W-1:0] cur_col_o,
    output logic [COL_W-1:0] fin_col_o,
    output logic             adv_go_o
);

    typedef struct packed {
        ptr_t             ptr;
        logic [COL_W-1:0] col;
    } roles_t;

    roles_t st_d, st_q;
    logic   go;

    always_comb begin
        go   = adv_req_i && !busy_i;
        st_d = st_q;
        if (go) begin
            st_d.ptr = ptr_add(st_q.ptr, 2'd1);
            st_d.col = st_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o     = st_q.ptr;
    assign cur_col_o = st_q.col;
    assign fin_col_o = st_q.col;
    assign adv_go_o  = go;

    // R8: a request seen while busy leaves the roles alone
    a_r8_stall_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (st_q.ptr == $past(st_q.ptr) && st_q.col == $past(st_q.col)));

endmodule

// File: rtl/cpipe_bank.sv
module cpipe_bank
    import cpipe_pkg::*;
#(
    parameter int ROWS  = 256,
    parameter int ACC_W = 12,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid_i,
    input  ptr_t             hit_buf_i,
    input  logic [ROW_W-1:0] hit_row_i,
    input  logic [ACC_W-1:0] hit_wt_i,
    input  logic             clr_en_i,
    input  ptr_t             clr_buf_i,
    input  logic [ROW_W-1:0] clr_row_i,
    output logic [ACC_W-1:0] clr_val_o
);

    logic [NBUF-1:0][ACC_W-1:0] rd_each;

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [ACC_W-1:0] mem_q [ROWS];
        logic [ACC_W:0]   sum;
        logic [ACC_W-1:0] sat;
        logic             hit_me, clr_me;

        always_comb begin
            hit_me = hit_valid_i && (hit_buf_i == ptr_t'(b));
            clr_me = clr_en_i && (clr_buf_i == ptr_t'(b));
            sum    = {1'b0, mem_q[hit_row_i]} + {1'b0, hit_wt_i};
            sat    = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
            end else if (hit_me) begin
                mem_q[hit_row_i] <= sat;
            end else if (clr_me) begin
                mem_q[clr_row_i] <= '0;
            end
        end

        assign rd_each[b] = mem_q[clr_row_i];
    end

    always_comb begin
        clr_val_o = '0;
        for (int b = 0; b < NBUF; b++)
            if (clr_buf_i == ptr_t'(b)) clr_val_o = rd_each[b];
    end

    // R9: the drained buffer is never the one taking hits
    a_r9_roles_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid_i && clr_en_i) |-> (hit_buf_i != clr_buf_i));

endmodule

// File: rtl/cpipe_recomb.sv
module cpipe_recomb #(
    parameter int ROWS  = 256,
    parameter int COLS  = 256,
    parameter int ACC_W = 12,
    parameter int PIX_W = 2,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int SH_W  = $clog2(ACC_W),
    localparam int ADR_W = COL_W + ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_go_i,
    input  logic [COL_W-1:0] fin_col_i,
    input  logic [SH_W-1:0]  shift_i,
    input  logic [ACC_W-1:0] clr_val_i,
    output logic             clr_en_o,
    output logic [ROW_W-1:0] clr_row_o,
    output logic             busy_o,
    output logic             scr_re_o,
    output logic [ADR_W-1:0] scr_raddr_o,
    input  logic [PIX_W-1:0] scr_rdata_i,
    output logic             scr_we_o,
    output logic [ADR_W-1:0] scr_waddr_o,
    output logic [PIX_W-1:0] scr_wdata_o
);

    localparam logic [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic             rd_act;
        logic [ROW_W-1:0] rd_row;
        logic [COL_W-1:0] rd_col;
        logic             wr_pend;
        logic [ROW_W-1:0] wr_row;
        logic [COL_W-1:0] wr_col;
        logic [PIX_W-1:0] wr_q;
    } rc_t;

    rc_t              st_d, st_q;
    logic [ACC_W-1:0] shifted;
    logic [PIX_W-1:0] quant;

    always_comb begin
        shifted = clr_val_i >> shift_i;
        quant   = (shifted > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : shifted[PIX_W-1:0];

        st_d         = st_q;
        st_d.wr_pend = st_q.rd_act;
        st_d.wr_row  = st_q.rd_row;
        st_d.wr_col  = st_q.rd_col;
        st_d.wr_q    = quant;
        if (st_q.rd_act) begin
            st_d.rd_row = st_q.rd_row + 1'b1;
            if (st_q.rd_row == ROW_W'(ROWS - 1)) st_d.rd_act = 1'b0;
        end else if (adv_go_i) begin
            st_d.rd_act = 1'b1;
            st_d.rd_row = '0;
            st_d.rd_col = fin_col_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_en_o    = st_q.rd_act;
    assign clr_row_o   = st_q.rd_row;
    assign busy_o      = st_q.rd_act || st_q.wr_pend;
    assign scr_re_o    = st_q.rd_act;
    assign scr_raddr_o = {st_q.rd_col, st_q.rd_row};
    assign scr_we_o    = st_q.wr_pend;
    assign scr_waddr_o = {st_q.wr_col, st_q.wr_row};
    assign scr_wdata_o = (scr_rdata_i > st_q.wr_q) ? scr_rdata_i : st_q.wr_q;

    // R5: each write repeats the address read one cycle earlier
    a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        scr_we_o |-> ($past(scr_re_o) && $past(scr_raddr_o) == scr_waddr_o));

    // R4: rows advance by one on consecutive read cycles
    a_r4_rows_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_re_o && $past(scr_re_o)) |->
        (scr_raddr_o[ROW_W-1:0] == $past(scr_raddr_o[ROW_W-1:0]) + 1'b1));

    // R8: an accepted advance raises busy on the next cycle
    a_r8_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        adv_go_i |=> busy_o);

endmodule

// File: rtl/colpipe_top.sv
module colpipe_top
    import cpipe_pkg::*;
#(
    parameter int ROWS  = 256,
    parameter int COLS  = 256,
    parameter int ACC_W = 12,
    parameter int PIX_W = 2,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int SH_W  = $clog2(ACC_W),
    localparam int ADR_W = COL_W + ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid_i,
    input  logic             hit_next_i,
    input  logic [ROW_W-1:0] hit_row_i,
    input  logic [ACC_W-1:0] hit_wt_i,
    input  logic             adv_req_i,
    input  logic [SH_W-1:0]  scale_shift_i,
    output logic             busy_o,
    output logic [COL_W-1:0] cur_col_o,
    output logic             scr_re_o,
    output logic [ADR_W-1:0] scr_raddr_o,
    input  logic [PIX_W-1:0] scr_rdata_i,
    output logic             scr_we_o,
    output logic [ADR_W-1:0] scr_waddr_o,
    output logic [PIX_W-1:0] scr_wdata_o
);

    ptr_t             ptr;
    ptr_t             hit_buf, clr_buf;
    logic [COL_W-1:0] fin_col;
    logic             adv_go;
    logic             clr_en;
    logic [ROW_W-1:0] clr_row;
    logic [ACC_W-1:0] clr_val;
    logic             busy;

    assign hit_buf = hit_next_i ? ptr_add(ptr, 2'd1) : ptr;
    assign clr_buf = ptr_add(ptr, 2'd2);
    assign busy_o  = busy;

    cpipe_roles #(.COLS(COLS)) u_roles (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_req_i (adv_req_i),
        .busy_i    (busy),
        .ptr_o     (ptr),
        .cur_col_o (cur_col_o),
        .fin_col_o (fin_col),
        .adv_go_o  (adv_go)
    );

    cpipe_bank #(.ROWS(ROWS), .ACC_W(ACC_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_valid_i (hit_valid_i),
        .hit_buf_i   (hit_buf),
        .hit_row_i   (hit_row_i),
        .hit_wt_i    (hit_wt_i),
        .clr_en_i    (clr_en),
        .clr_buf_i   (clr_buf),
        .clr_row_i   (clr_row),
        .clr_val_o   (clr_val)
    );

    cpipe_recomb #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W), .PIX_W(PIX_W)) u_recomb (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_go_i    (adv_go),
        .fin_col_i   (fin_col),
        .shift_i     (scale_shift_i),
        .clr_val_i   (clr_val),
        .clr_en_o    (clr_en),
        .clr_row_o   (clr_row),
        .busy_o      (busy),
        .scr_re_o    (scr_re_o),
        .scr_raddr_o (scr_raddr_o),
        .scr_rdata_i (scr_rdata_i),
        .scr_we_o    (scr_we_o),
        .scr_waddr_o (scr_waddr_o),
        .scr_wdata_o (scr_wdata_o)
    );

    // R1: no screen traffic without a drain in progress
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scr_re_o && !scr_we_o));

endmodule

// File: tb/sim_colpipe_top.sv
module sim_colpipe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid_i = 1'b0, hit_next_i = 1'b0, adv_req_i = 1'b0;
    logic [7:0]  hit_row_i = '0;
    logic [11:0] hit_wt_i = '0;
    logic [3:0]  scale_shift_i = '0;
    logic        busy_o, scr_re_o, scr_we_o;
    logic [7:0]  cur_col_o;
    logic [15:0] scr_raddr_o, scr_waddr_o;
    logic [1:0]  scr_rdata_i = '0, scr_wdata_o;

    always #5 clk = ~clk;

    colpipe_top u0 (.*);

    int n_cmp = 0, n_bad = 0;

    // screen RAM model and expected-screen shadow
    logic [1:0] scr_mem [int];
    logic [1:0] exp_scr [int];
    int cur_m [256], nxt_m [256], rc_m [256];
    int col_m = 0;
    int exp_q [$];

    function automatic int rd_scr(int a);
        return scr_mem.exists(a) ? int'(scr_mem[a]) : 0;
    endfunction
    function automatic int rd_exp(int a);
        return exp_scr.exists(a) ? int'(exp_scr[a]) : 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic preload(int x, int y, int v);
        scr_mem[x * 256 + y] = 2'(v);
        exp_scr[x * 256 + y] = 2'(v);
    endtask

    always @(posedge clk) begin
        if (scr_re_o) scr_rdata_i <= rd_scr(int'(scr_raddr_o));
        if (scr_we_o) scr_mem[int'(scr_waddr_o)] = scr_wdata_o;
    end

    // monitor: pop one expected item per screen write (R5, R6, R7, R9)
    always @(posedge clk) begin
        #2;
        if (rst_n && scr_we_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected write", int'(scr_waddr_o), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'({scr_waddr_o, scr_wdata_o}) == e, "R5/R6 merged write {addr,pix}",
                    int'({scr_waddr_o, scr_wdata_o}), e);
            end
        end
    end

    task automatic hit(bit nxt, int row, int wt);
        @(negedge clk);
        hit_valid_i = 1'b1; hit_next_i = nxt;
        hit_row_i = 8'(row); hit_wt_i = 12'(wt);
        if (nxt) nxt_m[row] = (nxt_m[row] + wt > 4095) ? 4095 : nxt_m[row] + wt;
        else     cur_m[row] = (cur_m[row] + wt > 4095) ? 4095 : cur_m[row] + wt;
        @(negedge clk);
        hit_valid_i = 1'b0;
    endtask

    task automatic advance();
        int x;
        x = col_m;
        for (int y = 0; y < 256; y++) begin
            int s, q, o, m;
            s = cur_m[y] >> scale_shift_i;
            q = (s > 3) ? 3 : s;
            o = rd_exp(x * 256 + y);
            m = (o > q) ? o : q;
            exp_scr[x * 256 + y] = 2'(m);
            exp_q.push_back(((x * 256 + y) << 2) | m);
        end
        for (int y = 0; y < 256; y++) begin
            rc_m[y] = cur_m[y]; cur_m[y] = nxt_m[y]; nxt_m[y] = 0;
        end
        col_m = (col_m + 1) % 256;
        @(negedge clk);
        chk(busy_o == 1'b0, "R3 idle before advance", int'(busy_o), 0);
        adv_req_i = 1'b1;
        @(negedge clk);
        adv_req_i = 1'b0;
        // R4: first read due in the cycle right after acceptance
        chk(scr_re_o == 1'b1, "R4 read starts", int'(scr_re_o), 1);
        chk(int'(scr_raddr_o) == x * 256, "R4 first read address", int'(scr_raddr_o), x * 256);
        chk(int'(cur_col_o) == col_m, "R3 column index advanced", int'(cur_col_o), col_m);
    endtask

    task automatic wait_idle(output int cycles);
        int guard;
        cycles = 1;
        guard = 0;
        while (busy_o && guard < 2000) begin
            @(negedge clk);
            if (busy_o) cycles++;
            guard++;
        end
        if (guard >= 2000) chk(1'b0, "watchdog busy stuck", guard, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        for (int y = 0; y < 256; y++) begin cur_m[y] = 0; nxt_m[y] = 0; rc_m[y] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(scr_re_o == 1'b0 && scr_we_o == 1'b0, "R1 screen idle", int'(scr_re_o | scr_we_o), 0);
        chk(cur_col_o == 8'd0, "R1 column index", int'(cur_col_o), 0);

        // R2 hits, including a saturating pair
        scale_shift_i = 4'd10;
        hit(1'b0, 0, 4000);
        hit(1'b0, 0, 200);
        hit(1'b0, 7, 1024);
        hit(1'b0, 255, 3000);
        hit(1'b0, 100, 1023);
        hit(1'b1, 3, 1);
        hit(1'b1, 4, 2);
        hit(1'b1, 9, 5);
        preload(0, 100, 2);

        // first drain, column 0
        advance();
        // R9: hits while draining
        hit(1'b0, 3, 2);
        hit(1'b1, 50, 7);
        // R8: request while busy is ignored
        @(negedge clk);
        adv_req_i = 1'b1;
        repeat (5) @(negedge clk);
        adv_req_i = 1'b0;
        wait_idle(cyc);
        repeat (3) @(negedge clk);
        chk(cur_col_o == 8'd1, "R8 stalled request ignored", int'(cur_col_o), 1);
        chk(exp_q.size() == 0, "R5 all column-0 writes seen", exp_q.size(), 0);

        // R6 with shift 0, merge with preloaded pixels
        scale_shift_i = 4'd0;
        preload(1, 4, 3);
        preload(1, 3, 1);
        preload(1, 200, 2);
        advance();
        wait_idle(cyc);
        chk(cyc == 257, "R8 busy length", cyc, 257);
        @(negedge clk);
        chk(busy_o == 1'b0, "R8 busy drops", int'(busy_o), 0);

        // R6 shift 1, column with hits made during an earlier drain (R9)
        scale_shift_i = 4'd1;
        advance();
        wait_idle(cyc);
        chk(cyc == 257, "R8 busy length second", cyc, 257);

        // R7: reused buffer must be empty, screen kept
        preload(3, 1, 1);
        preload(3, 255, 3);
        advance();
        wait_idle(cyc);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all writes of empty column seen", exp_q.size(), 0);
        chk(cur_col_o == 8'd4, "R3 column after four advances", int'(cur_col_o), 4);
        chk(rd_scr(3 * 256 + 255) == 3, "R7 screen pixel kept", rd_scr(3 * 256 + 255), 3);
        chk(rd_scr(0 * 256 + 0) == 3, "R2 saturated value drained", rd_scr(0), 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule